// File: doc/BRIEF.md
# SPI Bus Release Arbiter

This block lets a second SPI master borrow a shared bus from the local SPI engine. The other master pulls an active-low request line. The arbiter synchronizes that line and checks a configuration enable. It then either hands the bus over at once or waits for the local transfer to end. While the bus is lent out, the arbiter turns off the local drivers for SCK, MOSI and every chip-select. It reports the hand-over on an active-low acknowledge line.

Local transfer starts from the host also pass through the arbiter. A start that arrives while the bus is lent out, or while a transfer is still running, is kept pending. It is issued to the engine as a single-cycle pulse once the bus is owned and idle again. A transfer that is already running when a request arrives is never cut short by the request. The bus changes hands only after the engine drops its busy flag or the host cancels the transfer.

Top module: `spi_bus_yield`

## Requirements
- R1: After reset, `yield_ack_n` is 1, `sck_oe`, `mosi_oe` and all `cs_oe` bits are 1, and `engine_start` is 0.
- R2: `ext_req_n` passes through a two-stage synchronizer. Suppose it is driven low while the block is enabled and no transfer is running. Then `yield_ack_n` falls on the third rising clock edge after the change, and stays high on the two edges before it.
- R3: While `yield_en` is 0 and the bus is owned locally, a low `ext_req_n` has no effect: `yield_ack_n` and all output enables stay 1.
- R4: If `xfer_busy` is 1 when the synchronized request is seen, `yield_ack_n` stays 1. It falls on the first rising edge at which `xfer_busy` is sampled 0.
- R5: While the release is deferred, a 1 on `xfer_cancel` sampled at a rising edge releases the bus on that edge even though `xfer_busy` is still 1.
- R6: While the bus is released (`yield_ack_n` = 0), `sck_oe`, `mosi_oe` and every `cs_oe` bit are 0. The acknowledge and the enables change on the same edge.
- R7: A `local_start_req` pulse seen while the bus is released produces no `engine_start`. It is held, and `engine_start` pulses for one cycle on the edge after `yield_ack_n` returns to 1.
- R8: When `ext_req_n` returns high, `yield_ack_n` rises and the output enables return to 1 on the third rising edge after the change.
- R9: With the bus owned and idle, a `local_start_req` sampled at a rising edge makes `engine_start` 1 for exactly that one following cycle.
- R10: A `local_start_req` seen while `xfer_busy` is 1 is held. `engine_start` pulses on the first edge at which `xfer_busy` is sampled 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| yield_en | input | 1 | Configuration: 1 allows the bus to be lent out |
| ext_req_n | input | 1 | Asynchronous active-low release request from the other master |
| xfer_busy | input | 1 | Local SPI engine reports a transfer in progress |
| xfer_cancel | input | 1 | Host cancels the running transfer (one-cycle pulse) |
| local_start_req | input | 1 | Host asks for a local transfer (one-cycle pulse) |
| engine_start | output | 1 | One-cycle start pulse to the local SPI engine |
| sck_oe | output | 1 | Output enable for the local SCK driver |
| mosi_oe | output | 1 | Output enable for the local MOSI driver |
| cs_oe | output | NUM_CS | Output enables for the chip-select drivers |
| yield_ack_n | output | 1 | Active-low acknowledge: 0 while the bus is released |

## Verification
The properties assume the engine raises `xfer_busy` on the cycle after an `engine_start` pulse and keeps it high until the transfer ends. They also assume `xfer_cancel` and `local_start_req` are single-cycle pulses. The stimulus honours both assumptions: the bench raises `xfer_busy` right after each start pulse it sees and drives the pulses for one clock only. Between scenarios the bench keeps `ext_req_n` high long enough to clear the synchronizer. It changes `yield_en` only while no request is present, so every expected edge can be counted from a known synchronizer state.

// File: rtl/spi_yield_pkg.sv
package spi_yield_pkg;

  typedef enum logic [1:0] {
    BUS_OWNED   = 2'd0,
    BUS_DRAIN   = 2'd1,
    BUS_YIELDED = 2'd2
  } yield_state_e;

  // Ownership transition rule, kept apart so the bench can restate it.
  function automatic yield_state_e next_yield_state(
    input yield_state_e cur,
    input logic         en,
    input logic         req,
    input logic         busy,
    input logic         launched,
    input logic         cancel
  );
    yield_state_e nxt;
    nxt = cur;
    case (cur)
      BUS_OWNED: begin
        if (en && req) begin
          if (busy || launched) nxt = BUS_DRAIN;
          else                  nxt = BUS_YIELDED;
        end
      end
      BUS_DRAIN: begin
        if (!en || !req)           nxt = BUS_OWNED;
        else if (!busy || cancel)  nxt = BUS_YIELDED;
      end
      BUS_YIELDED: begin
        if (!req) nxt = BUS_OWNED;
      end
      default: nxt = BUS_OWNED;
    endcase
    return nxt;
  endfunction

  // A start may launch only on an owned, idle bus not about to be lent.
  function automatic logic start_permitted(
    input logic owned,
    input logic yielding,
    input logic busy,
    input logic launched
  );
    return owned && !yielding && !busy && !launched;
  endfunction

endpackage

// File: rtl/yield_sync.sv
module yield_sync #(
  parameter int STAGES   = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{IDLE_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/yield_fsm.sv
module yield_fsm
  import spi_yield_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         yield_en,
  input  logic         req_active,
  input  logic         xfer_busy,
  input  logic         xfer_cancel,
  input  logic         engine_start,
  output yield_state_e state,
  output logic         owned,
  output logic         released,
  output logic         yield_now
);
  yield_state_e state_d;

  always_comb begin
    state_d = next_yield_state(state, yield_en, req_active, xfer_busy,
                               engine_start, xfer_cancel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= BUS_OWNED;
    else        state <= state_d;
  end

  assign owned     = (state == BUS_OWNED);
  assign released  = (state == BUS_YIELDED);
  assign yield_now = owned && yield_en && req_active;
endmodule

// File: rtl/yield_start_gate.sv
module yield_start_gate
  import spi_yield_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic local_start_req,
  input  logic owned,
  input  logic yield_now,
  input  logic xfer_busy,
  output logic engine_start
);
  logic pending;
  logic want;
  logic fire;

  assign want = pending || local_start_req;
  assign fire = want && start_permitted(owned, yield_now, xfer_busy, engine_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending      <= 1'b0;
      engine_start <= 1'b0;
    end else begin
      pending      <= want && !fire;
      engine_start <= fire;
    end
  end
endmodule

// File: rtl/yield_oe_drive.sv
module yield_oe_drive #(
  parameter int NUM_CS = 9
) (
  input  logic              released,
  output logic              sck_oe,
  output logic              mosi_oe,
  output logic [NUM_CS-1:0] cs_oe
);
  assign sck_oe  = !released;
  assign mosi_oe = !released;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_oe[i] = !released;
  end
endmodule

// File: rtl/spi_bus_yield.sv
module spi_bus_yield
  import spi_yield_pkg::*;
#(
  parameter int NUM_CS      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              yield_en,
  input  logic              ext_req_n,
  input  logic              xfer_busy,
  input  logic              xfer_cancel,
  input  logic              local_start_req,
  output logic              engine_start,
  output logic              sck_oe,
  output logic              mosi_oe,
  output logic [NUM_CS-1:0] cs_oe,
  output logic              yield_ack_n
);
  logic         req_n_sync;
  logic         req_active;
  yield_state_e state;
  logic         owned;
  logic         released;
  logic         yield_now;

  yield_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_req_n),
    .dout (req_n_sync)
  );

  assign req_active = !req_n_sync;

  yield_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .yield_en    (yield_en),
    .req_active  (req_active),
    .xfer_busy   (xfer_busy),
    .xfer_cancel (xfer_cancel),
    .engine_start(engine_start),
    .state       (state),
    .owned       (owned),
    .released    (released),
    .yield_now   (yield_now)
  );

  yield_start_gate u_gate (
    .clk            (clk),
    .rst_n          (rst_n),
    .local_start_req(local_start_req),
    .owned          (owned),
    .yield_now      (yield_now),
    .xfer_busy      (xfer_busy),
    .engine_start   (engine_start)
  );

  yield_oe_drive #(.NUM_CS(NUM_CS)) u_oe (
    .released(released),
    .sck_oe  (sck_oe),
    .mosi_oe (mosi_oe),
    .cs_oe   (cs_oe)
  );

  assign yield_ack_n = !released;
endmodule

// File: rtl/spi_bus_yield_chk.sv
module spi_bus_yield_chk #(
  parameter int NUM_CS = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              yield_en,
  input logic              xfer_busy,
  input logic              xfer_cancel,
  input logic              req_active,
  input logic              engine_start,
  input logic              sck_oe,
  input logic              mosi_oe,
  input logic [NUM_CS-1:0] cs_oe,
  input logic              yield_ack_n
);
  // R6
  released_drivers_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !yield_ack_n |-> (!sck_oe && !mosi_oe && (cs_oe == '0)));

  // R6
  owned_drivers_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    yield_ack_n |-> (sck_oe && mosi_oe && (&cs_oe)));

  // R7
  no_start_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !yield_ack_n |-> !engine_start);

  // R3
  release_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(yield_ack_n) |-> $past(yield_en));

  // R4
  release_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(yield_ack_n) |-> ($past(!xfer_busy) || $past(xfer_cancel)));

  // R8
  reclaim_needs_withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(yield_ack_n) |-> !$past(req_active));

  // R9
  start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    engine_start |=> !engine_start);
endmodule

bind spi_bus_yield spi_bus_yield_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .yield_en    (yield_en),
  .xfer_busy   (xfer_busy),
  .xfer_cancel (xfer_cancel),
  .req_active  (req_active),
  .engine_start(engine_start),
  .sck_oe      (sck_oe),
  .mosi_oe     (mosi_oe),
  .cs_oe       (cs_oe),
  .yield_ack_n (yield_ack_n)
);

// File: tb/tb_spi_bus_yield.sv
`timescale 1ns/1ps
module tb_spi_bus_yield;
  localparam int NUM_CS = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic yield_en = 1'b1;
  logic ext_req_n = 1'b1;
  logic xfer_busy = 1'b0;
  logic xfer_cancel = 1'b0;
  logic local_start_req = 1'b0;
  logic engine_start, sck_oe, mosi_oe, yield_ack_n;
  logic [NUM_CS-1:0] cs_oe;

  always #2 clk = ~clk;

  spi_bus_yield #(.NUM_CS(NUM_CS)) dut (
    .clk(clk), .rst_n(rst_n), .yield_en(yield_en), .ext_req_n(ext_req_n),
    .xfer_busy(xfer_busy), .xfer_cancel(xfer_cancel),
    .local_start_req(local_start_req), .engine_start(engine_start),
    .sck_oe(sck_oe), .mosi_oe(mosi_oe), .cs_oe(cs_oe), .yield_ack_n(yield_ack_n)
  );

  typedef struct {
    int    cyc;
    logic  ack;
    logic  oe;
    logic  st;
    string req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always @(posedge clk) cyc++;

  task automatic chk(string r, string what, logic got, logic expv);
    n_checks++;
    if (got !== expv) begin
      n_errors++;
      $display("FAIL %s %s: got %b expected %b (cycle %0d)", r, what, got, expv, cyc);
    end
  endtask

  function automatic logic oe_state();
    logic [NUM_CS+1:0] all;
    all = {sck_oe, mosi_oe, cs_oe};
    if (&all)  return 1'b1;
    if (~|all) return 1'b0;
    return 1'bx;
  endfunction

  // Driver side: schedule an expectation d edges from now (x = do not care).
  task automatic expect_at(int d, logic ack, logic oe, logic st, string r);
    exp_t e;
    e.cyc = cyc + d; e.ack = ack; e.oe = oe; e.st = st; e.req = r;
    sb.push_back(e);
  endtask

  // Monitor: pop and compare as outputs settle after each edge.
  always @(negedge clk) begin : monitor
    exp_t it;
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      it = sb.pop_front();
      if (it.cyc < cyc) begin
        n_checks++; n_errors++;
        $display("FAIL %s missed slot: got cycle %0d expected cycle %0d", it.req, cyc, it.cyc);
      end else begin
        if (it.ack !== 1'bx) chk(it.req, "yield_ack_n", yield_ack_n, it.ack);
        if (it.oe  !== 1'bx) chk(it.req, "output enables", oe_state(), it.oe);
        if (it.st  !== 1'bx) chk(it.req, "engine_start", engine_start, it.st);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drain_sb();
    while (sb.size() > 0) @(negedge clk);
    step(1);
  endtask

  initial begin : watchdog
    #400000;
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin : stimulus
    step(3);
    // R1: values held during reset
    chk("R1", "yield_ack_n in reset", yield_ack_n, 1'b1);
    chk("R1", "output enables in reset", oe_state(), 1'b1);
    chk("R1", "engine_start in reset", engine_start, 1'b0);
    rst_n = 1'b1;
    expect_at(1, 1'b1, 1'b1, 1'b0, "R1");
    expect_at(2, 1'b1, 1'b1, 1'b0, "R1");
    drain_sb();

    // R2 R6: idle release after synchronizer latency
    ext_req_n = 1'b0;
    expect_at(1, 1'b1, 1'b1, 1'b0, "R2");
    expect_at(2, 1'b1, 1'b1, 1'b0, "R2");
    expect_at(3, 1'b0, 1'b0, 1'b0, "R6");
    expect_at(5, 1'b0, 1'b0, 1'b0, "R6");
    step(6);
    // R8: withdraw
    ext_req_n = 1'b1;
    expect_at(2, 1'b0, 1'b0, 1'b0, "R8");
    expect_at(3, 1'b1, 1'b1, 1'b0, "R8");
    drain_sb();
    step(2);

    // R3: disabled, request ignored
    yield_en = 1'b0;
    step(1);
    ext_req_n = 1'b0;
    for (int d = 1; d <= 7; d++) expect_at(d, 1'b1, 1'b1, 1'b0, "R3");
    step(8);
    ext_req_n = 1'b1;
    step(4);
    yield_en = 1'b1;
    drain_sb();

    // R9: start on owned idle bus, then R4: deferred release
    local_start_req = 1'b1;
    expect_at(1, 1'b1, 1'b1, 1'b1, "R9");
    expect_at(2, 1'b1, 1'b1, 1'b0, "R9");
    step(1);
    local_start_req = 1'b0;
    xfer_busy = 1'b1;
    step(1);
    ext_req_n = 1'b0;
    for (int d = 1; d <= 6; d++) expect_at(d, 1'b1, 1'b1, 1'b0, "R4");
    step(6);
    xfer_busy = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R4");
    step(3);
    ext_req_n = 1'b1;
    expect_at(3, 1'b1, 1'b1, 1'b0, "R8");
    drain_sb();
    step(2);

    // R5: cancel releases despite busy
    xfer_busy = 1'b1;
    step(1);
    ext_req_n = 1'b0;
    for (int d = 1; d <= 5; d++) expect_at(d, 1'b1, 1'b1, 1'b0, "R5");
    step(5);
    xfer_cancel = 1'b1;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R5");
    step(1);
    xfer_cancel = 1'b0;
    xfer_busy = 1'b0;
    expect_at(1, 1'b0, 1'b0, 1'b0, "R5");
    step(2);
    ext_req_n = 1'b1;
    expect_at(3, 1'b1, 1'b1, 1'b0, "R8");
    drain_sb();
    step(2);

    // R7: start held while released, issued after reclaim
    ext_req_n = 1'b0;
    expect_at(3, 1'b0, 1'b0, 1'b0, "R7");
    step(5);
    local_start_req = 1'b1;
    step(1);
    local_start_req = 1'b0;
    for (int d = 1; d <= 3; d++) expect_at(d, 1'b0, 1'b0, 1'b0, "R7");
    step(3);
    ext_req_n = 1'b1;
    expect_at(2, 1'b0, 1'b0, 1'b0, "R7");
    expect_at(3, 1'b1, 1'b1, 1'b0, "R7");
    expect_at(4, 1'b1, 1'b1, 1'b1, "R7");
    expect_at(5, 1'b1, 1'b1, 1'b0, "R7");
    step(5);
    xfer_busy = 1'b1;
    step(3);
    xfer_busy = 1'b0;
    drain_sb();
    step(2);

    // R10: start held while the engine is busy
    xfer_busy = 1'b1;
    step(1);
    local_start_req = 1'b1;
    for (int d = 1; d <= 3; d++) expect_at(d, 1'b1, 1'b1, 1'b0, "R10");
    step(1);
    local_start_req = 1'b0;
    step(2);
    xfer_busy = 1'b0;
    expect_at(1, 1'b1, 1'b1, 1'b1, "R10");
    expect_at(2, 1'b1, 1'b1, 1'b0, "R10");
    step(1);
    xfer_busy = 1'b1;
    step(3);
    xfer_busy = 1'b0;
    drain_sb();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule